// File: doc/BRIEF.md
# Multispeed Data-Strobe Transmit Encoder

This block turns parallel packet data from the link side into a serial bit stream and its companion strobe stream for a cable transmitter. A new word is taken once per system-clock period, which is eight periods of the bit-rate reference. The packet speed decides how many of the word's lanes carry payload: two at the lowest speed, four at the middle speed and all eight at the highest. Because every speed fills exactly one system-clock period, the three output rates are 98.304, 196.608 and 393.216 Mbit/s.

The block runs on the reference-rate clock. A reference enable marks each reference period. The system-clock boundary is derived inside the block by counting eight enabled reference ticks from reset. The serial bit is sent on the data output, which drives the B pair. The strobe output drives the A pair. The strobe changes only when the data bit repeats, so exactly one of the two outputs changes per bit period. A receiver recovers the bit clock from their XOR.

Top module: `dsx_tx_encoder`

## Requirements
- R1: A synchronous active-high reset drives both ds_data and ds_strobe to 0. No bit is sent until a word with tx_valid high has been captured.
- R2: tx_word, tx_valid and tx_speed are captured together on every eighth enabled reference tick. The first capture is on the eighth enabled tick after reset is released.
- R3: tx_speed 00 selects the lowest speed, using lanes tx_word[7:6]. 01 selects the middle speed, using tx_word[7:4]. 10 selects the highest speed, using tx_word[7:0]. The code 11 behaves like 00. Lanes a speed does not use have no effect on the outputs.
- R4: After a capture, bit periods start every 4 enabled ticks at the lowest speed, every 2 at the middle speed and every tick at the highest. The first bit appears on the first enabled tick after the capture.
- R5: The lanes are sent most significant first: tx_word[7] is sent first, then bits in descending index order.
- R6: In each bit period of a valid word, ds_data takes the value of the bit being sent.
- R7: ds_strobe inverts when the new bit equals the previous ds_data value and holds otherwise. As a result, ds_data XOR ds_strobe flips once per bit period.
- R8: While a word captured with tx_valid low is in progress, ds_data and ds_strobe hold their values.
- R9: A clock cycle with ref_ce low changes neither the outputs nor the word boundary or bit timing.
- R10: Changes on tx_word, tx_valid or tx_speed between capture ticks have no effect until the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_ce | input | 1 | Enable marking one bit-rate reference period |
| tx_word | input | WORD_W | Parallel payload lanes, lane 0 at the MSB |
| tx_valid | input | 1 | Word carries payload |
| tx_speed | input | 2 | Packet speed code |
| ds_data | output | 1 | Encoded data bit (B pair) |
| ds_strobe | output | 1 | Encoded strobe bit (A pair) |

## Verification
On every cycle, the checker confirms four things. Outputs stay frozen outside a valid bit period. The data-XOR-strobe signal flips on each valid bit period. A low reference enable stops every internal tick. Capture ticks never occur back to back. Only the bench's scenarios can show which bit goes out at which instant. That includes MSB-first order across the three speeds, the alias of the reserved speed code, the ignored low lanes, and late changes on the inputs having no effect. The bench compares against a bit-level model on every cycle, including runs with a gated reference enable.

// File: rtl/dsx_pkg.sv
package dsx_pkg;

  typedef enum logic [1:0] {
    SPD_S100 = 2'd0,
    SPD_S200 = 2'd1,
    SPD_S400 = 2'd2,
    SPD_RSV  = 2'd3
  } speed_e;

  // Number of distinct speeds that carry traffic.
  localparam int unsigned NUM_SPEEDS = 3;

  // The reserved code is mapped onto the slowest speed.
  function automatic speed_e norm_speed(input logic [1:0] raw);
    speed_e s;
    if (raw == 2'd3) s = SPD_S100;
    else             s = speed_e'(raw);
    return s;
  endfunction

  // Reference ticks per bit minus one: 3, 1, 0 for the three speeds.
  function automatic int unsigned tick_mask(input speed_e s);
    int unsigned sh;
    sh = (s == SPD_S400) ? 0 : (s == SPD_S200) ? 1 : 2;
    return (32'd1 << sh) - 32'd1;
  endfunction

endpackage

// File: rtl/dsx_tick_gen.sv
module dsx_tick_gen
  import dsx_pkg::*;
#(
  parameter int unsigned REF_PER_WORD = 8,
  localparam int unsigned PH_W = $clog2(REF_PER_WORD)
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   ref_ce,
  input  speed_e cur_speed,
  output logic   word_ce,
  output logic   bit_ce
);

  logic [PH_W-1:0]       phase;
  logic [NUM_SPEEDS-1:0] spd_tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
    end else if (ref_ce) begin
      if (phase == PH_W'(REF_PER_WORD - 1)) phase <= '0;
      else                                  phase <= phase + 1'b1;
    end
  end

  assign word_ce = ref_ce && (phase == PH_W'(REF_PER_WORD - 1));

  // One candidate bit tick per speed; the latched speed picks one.
  for (genvar g = 0; g < NUM_SPEEDS; g++) begin : g_spd
    localparam logic [PH_W-1:0] MASK = PH_W'(tick_mask(speed_e'(g)));
    assign spd_tick[g] = ref_ce && ((phase & MASK) == '0);
  end

  always_comb begin
    case (cur_speed)
      SPD_S400: bit_ce = spd_tick[2];
      SPD_S200: bit_ce = spd_tick[1];
      default:  bit_ce = spd_tick[0];
    endcase
  end

endmodule

// File: rtl/dsx_word_reg.sv
module dsx_word_reg
  import dsx_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_ce,
  input  logic              bit_ce,
  input  logic [WORD_W-1:0] word_in,
  input  logic              valid_in,
  input  logic [1:0]        speed_in,
  output logic              cur_bit,
  output logic              cur_valid,
  output speed_e            cur_speed
);

  logic [WORD_W-1:0] shreg;

  // Capture wins over shifting: the last bit of the old word is read
  // from shreg by the encoder on the same edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      cur_valid <= 1'b0;
      cur_speed <= SPD_S100;
    end else if (word_ce) begin
      shreg     <= word_in;
      cur_valid <= valid_in;
      cur_speed <= norm_speed(speed_in);
    end else if (bit_ce) begin
      shreg     <= {shreg[WORD_W-2:0], 1'b0};
    end
  end

  assign cur_bit = shreg[WORD_W-1];

endmodule

// File: rtl/dsx_ds_enc.sv
module dsx_ds_enc (
  input  logic clk,
  input  logic rst,
  input  logic bit_ce,
  input  logic cur_valid,
  input  logic cur_bit,
  output logic ds_data,
  output logic ds_strobe
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ds_data   <= 1'b0;
      ds_strobe <= 1'b0;
    end else if (bit_ce && cur_valid) begin
      ds_data <= cur_bit;
      if (cur_bit == ds_data) ds_strobe <= ~ds_strobe;
    end
  end

endmodule

// File: rtl/dsx_tx_encoder.sv
module dsx_tx_encoder
  import dsx_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_ce,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              tx_valid,
  input  logic [1:0]        tx_speed,
  output logic              ds_data,
  output logic              ds_strobe
);

  // At the top speed one bit fills one reference tick.
  localparam int unsigned REF_PER_WORD = WORD_W;

  logic   word_ce;
  logic   bit_ce;
  logic   cur_bit;
  logic   cur_valid;
  speed_e cur_speed;

  dsx_tick_gen #(.REF_PER_WORD(REF_PER_WORD)) u_tick (
    .clk       (clk),
    .rst       (rst),
    .ref_ce    (ref_ce),
    .cur_speed (cur_speed),
    .word_ce   (word_ce),
    .bit_ce    (bit_ce)
  );

  dsx_word_reg #(.WORD_W(WORD_W)) u_word (
    .clk       (clk),
    .rst       (rst),
    .word_ce   (word_ce),
    .bit_ce    (bit_ce),
    .word_in   (tx_word),
    .valid_in  (tx_valid),
    .speed_in  (tx_speed),
    .cur_bit   (cur_bit),
    .cur_valid (cur_valid),
    .cur_speed (cur_speed)
  );

  dsx_ds_enc u_enc (
    .clk       (clk),
    .rst       (rst),
    .bit_ce    (bit_ce),
    .cur_valid (cur_valid),
    .cur_bit   (cur_bit),
    .ds_data   (ds_data),
    .ds_strobe (ds_strobe)
  );

endmodule

// File: rtl/dsx_tx_encoder_chk.sv
module dsx_tx_encoder_chk (
  input logic clk,
  input logic rst,
  input logic ref_ce,
  input logic word_ce,
  input logic bit_ce,
  input logic cur_valid,
  input logic ds_data,
  input logic ds_strobe
);

  assert_reset_zero_R1: assert property (@(posedge clk)
    $past(rst) |-> (!ds_data && !ds_strobe));

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !(bit_ce && cur_valid) |=> ($stable(ds_data) && $stable(ds_strobe)));

  assert_one_flip_R7: assert property (@(posedge clk) disable iff (rst)
    (bit_ce && cur_valid) |=> ((ds_data ^ ds_strobe) != $past(ds_data ^ ds_strobe)));

  assert_gate_ticks_R9: assert property (@(posedge clk) disable iff (rst)
    !ref_ce |-> (!word_ce && !bit_ce));

  assert_spaced_capture_R2: assert property (@(posedge clk) disable iff (rst)
    word_ce |=> !word_ce);

endmodule

bind dsx_tx_encoder dsx_tx_encoder_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .ref_ce    (ref_ce),
  .word_ce   (word_ce),
  .bit_ce    (bit_ce),
  .cur_valid (cur_valid),
  .ds_data   (ds_data),
  .ds_strobe (ds_strobe)
);

// File: tb/dsx_tx_encoder_tb.sv
module dsx_tx_encoder_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_ce = 1'b1;
  logic [7:0] tx_word = 8'h00;
  logic       tx_valid = 1'b0;
  logic [1:0] tx_speed = 2'd0;
  logic       ds_data;
  logic       ds_strobe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";

  // Model state
  int m_cnt = 0;
  int m_valid = 0;
  int m_speed = 0;
  logic [7:0] m_bits = 8'h00;
  logic m_d = 1'b0;
  logic m_s = 1'b0;

  always #10 clk = ~clk;

  dsx_tx_encoder #(.WORD_W(8)) u_dut (
    .clk(clk), .rst(rst), .ref_ce(ref_ce), .tx_word(tx_word),
    .tx_valid(tx_valid), .tx_speed(tx_speed),
    .ds_data(ds_data), .ds_strobe(ds_strobe)
  );

  // Ticks per bit from the speed code (R3, R4); 11 acts as 00.
  function automatic int ticks_per_bit(input int spd);
    if (spd == 2) return 1;
    if (spd == 1) return 2;
    return 4;
  endfunction

  // Advance the model by the edge just passed, then compare.
  task automatic step();
    int tpb;
    logic b;
    @(negedge clk);
    cycles++;
    if (rst) begin
      m_cnt = 0; m_valid = 0; m_speed = 0; m_bits = 8'h00;
      m_d = 1'b0; m_s = 1'b0;
    end else if (ref_ce) begin
      tpb = ticks_per_bit(m_speed);
      if (m_valid != 0 && (m_cnt % tpb) == 0) begin
        b = m_bits[7 - m_cnt / tpb];
        if (b == m_d) m_s = ~m_s;
        m_d = b;
      end
      if (m_cnt == 7) begin
        m_valid = tx_valid ? 1 : 0;
        m_speed = (tx_speed == 2'd3) ? 0 : int'(tx_speed);
        m_bits  = tx_word;
      end
      m_cnt = (m_cnt + 1) % 8;
    end
    checks++;
    if (ds_data !== m_d || ds_strobe !== m_s) begin
      errors++;
      $display("FAIL %s: cycle %0d data/strobe actual %b%b expected %b%b",
               cur_req, cycles, ds_data, ds_strobe, m_d, m_s);
    end
  endtask

  task automatic run_words(input int n, input logic [1:0] spd, input logic [7:0] w0,
                           input int rnd);
    for (int i = 0; i < n * 8; i++) begin
      tx_speed = spd;
      tx_valid = 1'b1;
      tx_word  = (rnd != 0) ? 8'($urandom) : w0;
      step();
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0d15));
    // R1: reset state
    cur_req = "R1";
    repeat (4) step();
    checks++;
    if (ds_data !== 1'b0 || ds_strobe !== 1'b0) begin
      errors++;
      $display("FAIL R1: outputs actual %b%b expected 00", ds_data, ds_strobe);
    end
    rst = 1'b0;
    // R2: capture on 8th enabled tick; no output before then with payload ready
    cur_req = "R2";
    tx_word = 8'hFF; tx_valid = 1'b1; tx_speed = 2'd2;
    repeat (8) step();
    checks++;
    if (ds_data !== 1'b0) begin
      errors++;
      $display("FAIL R2: data before first capture actual %b expected 0", ds_data);
    end
    step();
    checks++;
    if (ds_data !== 1'b1) begin
      errors++;
      $display("FAIL R2: first bit after capture actual %b expected 1", ds_data);
    end
    // R5/R6: MSB-first at top speed
    cur_req = "R5";
    run_words(4, 2'd2, 8'hB2, 0);
    cur_req = "R6";
    run_words(4, 2'd2, 8'h5A, 0);
    // R7: repeated bits toggle strobe, alternating bits hold it
    cur_req = "R7";
    run_words(3, 2'd2, 8'h00, 0);
    run_words(3, 2'd2, 8'hFF, 0);
    run_words(3, 2'd2, 8'hAA, 0);
    // R3: lane selection, unused low lanes random, reserved code
    cur_req = "R3";
    run_words(6, 2'd0, 8'h80, 0);
    run_words(10, 2'd0, 8'h00, 1);
    run_words(10, 2'd3, 8'h00, 1);
    // R4: middle speed timing
    cur_req = "R4";
    run_words(10, 2'd1, 8'h00, 1);
    // R8: invalid words freeze outputs
    cur_req = "R8";
    for (int i = 0; i < 48; i++) begin
      tx_valid = 1'b0; tx_word = 8'($urandom); tx_speed = 2'($urandom);
      step();
    end
    // R9: gated reference enable
    cur_req = "R9";
    for (int i = 0; i < 600; i++) begin
      ref_ce = ($urandom % 3) != 0;
      tx_valid = 1'b1; tx_word = 8'($urandom); tx_speed = 2'($urandom);
      step();
    end
    ref_ce = 1'b1;
    // R10: inputs change every cycle, only capture matters
    cur_req = "R10";
    for (int i = 0; i < 2000; i++) begin
      tx_valid = ($urandom % 5) != 0;
      tx_word = 8'($urandom); tx_speed = 2'($urandom);
      ref_ce = ($urandom % 8) != 0;
      step();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule